// File: doc/BRIEF.md
# Core Power-Up Sequencer

This block takes one processor core from fully off to running. A single-cycle start pulse launches a fixed, timed sequence. First the block raises a supply-rail request that carries an 8-bit voltage code. It then moves a 32-bit power-control word through a series of clamp, cache-sleep and power-on-reset phases. Each phase holds for a minimum time that is counted in clock cycles.

The parameter `CLK_MHZ` gives the number of clock cycles per microsecond. Every wait is given in microseconds or nanoseconds and is turned into a cycle count when the design is built. While a sequence runs, `busy` is high and further start pulses have no effect. When the powered-up bit is first driven, `done` pulses for one cycle. The final word and the rail request then stay in place until the next start or reset.

States and transitions: `S_IDLE` goes to `S_RAIL` on start. `S_RAIL` goes to `S_L2ON` when the rail wait expires. `S_L2ON` goes to `S_SETTLE` after one cycle. `S_SETTLE` goes to `S_PORHOLD` on expiry. `S_PORHOLD` goes to `S_UNCLAMP` on expiry. `S_UNCLAMP` goes to `S_RELEASE` on expiry. `S_RELEASE` goes to `S_UP` on expiry. `S_UP` goes to `S_ON` after one cycle. `S_ON` goes back to `S_RAIL` on start. Synchronous reset forces `S_IDLE` from any state.

Top module: `pwrseq_core`

## Requirements
- R1: While reset (`rst_n` low) is sampled, and after it, until a start arrives, `rail_req`, `rail_code`, `ctrl_word`, `busy` and `done` are all zero.
- R2: In the first cycle after a start is sampled in an idle state, `rail_req` and `busy` are high and `rail_code` is 0xA4. Whenever `rail_req` is low, `rail_code` is 0.
- R3: For the first `RAIL_US*CLK_MHZ` cycles of a sequence, `ctrl_word` stays 0.
- R4: The word is then 0x109 (bit 8 PLL clamp, bit 3 cache sleep, bit 0 I/O clamp) for exactly one cycle. It then becomes 0x101 for the settle time. Bit 4 (core reset) is never set.
- R5: Next the word is 0x121 (bit 5 power-on reset added) for `POR_US*CLK_MHZ` cycles.
- R6: Next the word is 0x120 (I/O clamp released while reset is held) for `UNCLAMP_US*CLK_MHZ` cycles.
- R7: Next the word is 0x100 (reset released) for `RELEASE_US*CLK_MHZ` cycles.
- R8: The word then becomes 0x180 (bit 7 powered-up). `done` is high only in that first cycle and `busy` is low from the next cycle. The word and `rail_req` then hold.
- R9: The settle time in cycles is `ceil(SETTLE_NS*CLK_MHZ/1000)`, and never less than 1.
- R10: A start pulse while `busy` is high changes neither the outputs nor the timing of the sequence.
- R11: A start while powered up (not busy) begins a new sequence from the rail step, with the word back at 0.
- R12: Reset asserted in the middle of a sequence returns every output to zero at the next clock edge, and the block stays idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| rail_req | output | 1 | Supply-rail request |
| rail_code | output | 8 | Voltage code, valid while `rail_req` is high |
| ctrl_word | output | 32 | Power-control word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the powered-up bit is first driven |

## Verification
All outputs decode directly from the state register. Every result therefore appears one clock edge after the input or timer expiry that causes it: the rail request is visible in the first cycle after the start edge, and each word phase lasts exactly its computed cycle count. The bench drives inputs and samples outputs on the falling edge, and walks a phase table one cycle at a time. It compares every cycle of every phase against that phase's expected word, so a phase that is one cycle too short or too long moves the next word onto a sampled cycle where it is caught. Two instances with different clock rates cover both the rounded-up and the one-cycle-minimum settle times.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RAIL,
        S_L2ON,
        S_SETTLE,
        S_PORHOLD,
        S_UNCLAMP,
        S_RELEASE,
        S_UP,
        S_ON
    } seq_state_t;

    localparam int BIT_PLL_CLAMP = 8;
    localparam int BIT_PWRUP     = 7;
    localparam int BIT_POR       = 5;
    localparam int BIT_CORE_RST  = 4;
    localparam int BIT_L2_SLP    = 3;
    localparam int BIT_IO_CLAMP  = 0;

    function automatic int us_cycles(input int us, input int mhz);
        int c;
        c = us * mhz;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int ns_cycles(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit_m1,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    assign expire = (cnt_q >= limit_m1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwrseq_word.sv
module pwrseq_word
    import pwrseq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  seq_state_t        st,
    output logic [WORD_W-1:0] word
);

    always_comb begin
        word = '0;
        unique case (st)
            S_IDLE, S_RAIL: ;
            S_L2ON: begin
                word[BIT_PLL_CLAMP] = 1'b1;
                word[BIT_L2_SLP]    = 1'b1;
                word[BIT_IO_CLAMP]  = 1'b1;
            end
            S_SETTLE: begin
                word[BIT_PLL_CLAMP] = 1'b1;
                word[BIT_IO_CLAMP]  = 1'b1;
            end
            S_PORHOLD: begin
                word[BIT_PLL_CLAMP] = 1'b1;
                word[BIT_POR]       = 1'b1;
                word[BIT_IO_CLAMP]  = 1'b1;
            end
            S_UNCLAMP: begin
                word[BIT_PLL_CLAMP] = 1'b1;
                word[BIT_POR]       = 1'b1;
            end
            S_RELEASE: begin
                word[BIT_PLL_CLAMP] = 1'b1;
            end
            S_UP, S_ON: begin
                word[BIT_PLL_CLAMP] = 1'b1;
                word[BIT_PWRUP]     = 1'b1;
            end
            default: ;
        endcase
        word[BIT_CORE_RST] = 1'b0;
    end

endmodule

// File: rtl/pwrseq_core.sv
module pwrseq_core
    import pwrseq_pkg::*;
#(
    parameter int         CLK_MHZ    = 200,
    parameter int         WORD_W     = 32,
    parameter int         RAIL_US    = 512,
    parameter int         SETTLE_NS  = 300,
    parameter int         POR_US     = 2,
    parameter int         UNCLAMP_US = 2,
    parameter int         RELEASE_US = 100,
    parameter logic [7:0] RAIL_CODE  = 8'hA4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rail_req,
    output logic [7:0]        rail_code,
    output logic [WORD_W-1:0] ctrl_word,
    output logic              busy,
    output logic              done
);

    localparam int RAIL_CYC    = us_cycles(RAIL_US, CLK_MHZ);
    localparam int SETTLE_CYC  = ns_cycles(SETTLE_NS, CLK_MHZ);
    localparam int POR_CYC     = us_cycles(POR_US, CLK_MHZ);
    localparam int UNCLAMP_CYC = us_cycles(UNCLAMP_US, CLK_MHZ);
    localparam int RELEASE_CYC = us_cycles(RELEASE_US, CLK_MHZ);
    localparam int MAX_CYC     = max2(max2(RAIL_CYC, RELEASE_CYC),
                                      max2(SETTLE_CYC, max2(POR_CYC, UNCLAMP_CYC)));
    localparam int CNT_W       = $clog2(MAX_CYC + 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] limit_m1;
    logic             expire;
    logic             clr;

    // wait length of the current state, minus one
    always_comb begin
        unique case (state_q)
            S_RAIL:    limit_m1 = CNT_W'(RAIL_CYC - 1);
            S_SETTLE:  limit_m1 = CNT_W'(SETTLE_CYC - 1);
            S_PORHOLD: limit_m1 = CNT_W'(POR_CYC - 1);
            S_UNCLAMP: limit_m1 = CNT_W'(UNCLAMP_CYC - 1);
            S_RELEASE: limit_m1 = CNT_W'(RELEASE_CYC - 1);
            default:   limit_m1 = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start)  state_d = S_RAIL;
            S_RAIL:    if (expire) state_d = S_L2ON;
            S_L2ON:                state_d = S_SETTLE;
            S_SETTLE:  if (expire) state_d = S_PORHOLD;
            S_PORHOLD: if (expire) state_d = S_UNCLAMP;
            S_UNCLAMP: if (expire) state_d = S_RELEASE;
            S_RELEASE: if (expire) state_d = S_UP;
            S_UP:                  state_d = S_ON;
            S_ON:      if (start)  state_d = S_RAIL;
            default:               state_d = S_IDLE;
        endcase
    end

    assign clr = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    pwrseq_timer #(
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .limit_m1 (limit_m1),
        .expire   (expire)
    );

    pwrseq_word #(
        .WORD_W (WORD_W)
    ) u_word (
        .st   (state_q),
        .word (ctrl_word)
    );

    always_comb begin
        rail_req  = (state_q != S_IDLE);
        rail_code = rail_req ? RAIL_CODE : 8'h00;
        busy      = (state_q != S_IDLE) && (state_q != S_ON);
        done      = (state_q == S_UP);
    end

    // R2: a sequence starts with the rail up and the word still clear
    a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rail_req && ctrl_word == '0));

    // R4: cache-sleep bit rises only once the rail request is up
    a_r4_l2_after_rail: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_word[BIT_L2_SLP]) |-> rail_req);

    // R6: the I/O clamp is released only while power-on reset is held
    a_r6_unclamp_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_word[BIT_IO_CLAMP]) |-> ctrl_word[BIT_POR]);

    // R7: powered-up bit rises only with reset and clamp both released
    a_r7_pwrup_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_word[BIT_PWRUP]) |-> (!ctrl_word[BIT_POR] && !ctrl_word[BIT_IO_CLAMP]));

    // R8: done comes with the first cycle of the powered-up bit, then busy drops
    a_r8_done_edge: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctrl_word[BIT_PWRUP] && !$past(ctrl_word[BIT_PWRUP])));
    a_r8_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10: a start during a sequence does not cut it short
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy);

endmodule

// File: tb/sim_pwrseq_core.sv
module sim_pwrseq_core;

    localparam int MHZ_A = 4;
    localparam int MHZ_B = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st0 = 1'b0;
    logic        st1 = 1'b0;
    logic        rq0, rq1, by0, by1, dn0, dn1;
    logic [7:0]  cd0, cd1;
    logic [31:0] w0, w1;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    pwrseq_core #(.CLK_MHZ(MHZ_A)) u0 (
        .clk(clk), .rst_n(rst_n), .start(st0), .rail_req(rq0),
        .rail_code(cd0), .ctrl_word(w0), .busy(by0), .done(dn0));

    pwrseq_core #(.CLK_MHZ(MHZ_B)) u1 (
        .clk(clk), .rst_n(rst_n), .start(st1), .rail_req(rq1),
        .rail_code(cd1), .ctrl_word(w1), .busy(by1), .done(dn1));

    // phase table: expected word, duration kind, done flag
    localparam int NPH = 7;
    localparam logic [31:0] PH_WORD [NPH] = '{32'h0, 32'h109, 32'h101, 32'h121,
                                              32'h120, 32'h100, 32'h180};
    localparam int PH_KIND [NPH] = '{0, 9, 1, 2, 3, 4, 9};
    localparam bit PH_DONE [NPH] = '{0, 0, 0, 0, 0, 0, 1};

    function automatic int dur(input int kind, input int mhz);
        int c;
        case (kind)
            0: c = 512 * mhz;
            1: begin c = (300 * mhz + 999) / 1000; if (c < 1) c = 1; end
            2: c = 2 * mhz;
            3: c = 2 * mhz;
            4: c = 100 * mhz;
            default: c = 1;
        endcase
        return c;
    endfunction

    function automatic string req_of(input int p);
        case (p)
            0: return "R3";
            1: return "R4";
            2: return "R4/R9";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic get(input int which, output logic [31:0] w, output logic rq,
                       output logic [7:0] cd, output logic by, output logic dn);
        if (which == 0) begin w = w0; rq = rq0; cd = cd0; by = by0; dn = dn0; end
        else            begin w = w1; rq = rq1; cd = cd1; by = by1; dn = dn1; end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_start(input int which, input logic v);
        if (which == 0) st0 = v; else st1 = v;
    endtask

    task automatic check_idle(input int which, input string req);
        logic [31:0] w; logic rq, by, dn; logic [7:0] cd;
        get(which, w, rq, cd, by, dn);
        check(w == 0 && !rq && cd == 0 && !by && !dn, req, "idle outputs",
              {w[27:0], rq, by, dn, |cd}, 32'h0);
    endtask

    // called on a falling edge; launches a run and walks every phase cycle by cycle
    task automatic walk(input int which, input int mhz, input int poke_ph);
        logic [31:0] w; logic rq, by, dn; logic [7:0] cd;
        set_start(which, 1'b1);
        @(negedge clk);
        set_start(which, 1'b0);
        get(which, w, rq, cd, by, dn);
        check(rq && by && cd == 8'hA4 && w == 0, "R2", "rail up at launch",
              {w[22:0], rq, cd}, {23'h0, 1'b1, 8'hA4});
        for (int p = 0; p < NPH; p++) begin
            bit bad = 0;
            for (int k = 0; k < dur(PH_KIND[p], mhz); k++) begin
                get(which, w, rq, cd, by, dn);
                if (!bad && (w != PH_WORD[p] || !rq || cd != 8'hA4 ||
                             !by || dn != PH_DONE[p])) begin
                    bad = 1;
                    $display("FAIL %s phase %0d cycle %0d: actual=%h/rq%0b/by%0b/dn%0b expected=%h/rq1/by1/dn%0b",
                             req_of(p), p, k, w, rq, by, dn, PH_WORD[p], PH_DONE[p]);
                end
                set_start(which, (p == poke_ph && k == 1) ? 1'b1 : 1'b0);
                @(negedge clk);
            end
            set_start(which, 1'b0);
            checks++;
            if (bad) failures++;
        end
        get(which, w, rq, cd, by, dn);
        check(w == 32'h180 && rq && !by && !dn, "R8", "powered-up hold",
              {w[28:0], rq, by, dn}, {29'h180, 3'b100});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                failures++;
                $display("FAIL watchdog: actual=%0d expected<100000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle(0, "R1");
        check_idle(1, "R1");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_idle(0, "R1");

        // R2-R8 at 4 MHz-equivalent
        walk(0, MHZ_A, -1);
        // R9: settle rounds 0.9 cycles up to 1
        check(dur(1, MHZ_B) == 1, "R9", "settle minimum", dur(1, MHZ_B), 1);
        walk(1, MHZ_B, -1);
        // R11 relaunch from powered-up, R10 start poked during reset hold
        walk(0, MHZ_A, 3);
        check(1'b1, "R11", "relaunch walk completed", 0, 0);
        // R10 start poked during rail wait
        walk(1, MHZ_B, 0);

        // R12: reset in mid sequence
        st0 = 1'b1;
        @(negedge clk);
        st0 = 1'b0;
        repeat (100) @(negedge clk);
        begin
            logic [31:0] w; logic rq, by, dn; logic [7:0] cd;
            get(0, w, rq, cd, by, dn);
            check(rq && by, "R12", "running before reset", {30'h0, rq, by}, 32'h3);
        end
        rst_n = 1'b0;
        @(negedge clk);
        check_idle(0, "R12");
        check_idle(1, "R12");
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check_idle(0, "R12");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule